// File: doc/BRIEF.md
# Shared-multiple parallel polynomial multiplier

This block multiplies a public polynomial with 13-bit coefficients by a secret polynomial whose coefficients lie between -4 and +4. The ring is the negacyclic ring modulo x^N + 1, and coefficient arithmetic is modulo 2^13. The whole secret polynomial sits in a register buffer of N 4-bit entries. The whole result sits in a register accumulator of N 13-bit entries. There are N parallel lanes. Each cycle the block takes one public coefficient a. It forms the multiples 0, a, 2a, 3a and 4a once and sends them to every lane. Each lane picks one multiple by the magnitude of its secret coefficient, then adds it to or subtracts it from its accumulator entry. In the same cycle the secret buffer rotates by one place, and the entry that wraps from the top to index 0 has its sign flipped.

Operands arrive as 64-bit words over a valid/ready input. The secret words come first, then the public words. A one-cycle `done` pulse ends each run. The result is then read one coefficient at a time through a combinational index port.

The controller has four states. ST_IDLE waits for `start`. Taking `start` clears the accumulator and the unpacker, then moves to ST_LOAD. ST_LOAD accepts N/16 secret words and moves to ST_RUN after the last one. ST_RUN accepts public words and processes one coefficient per cycle whenever at least 13 buffered bits are present. After coefficient N-1 it moves to ST_FIN. ST_FIN raises `done` for its single cycle and returns to ST_IDLE.

Top module: `polymul_shared`

## Requirements
- R1: After reset, `done` and `word_ready` are low and every accumulator coefficient read through `rd_coef` is zero.
- R2: In ST_LOAD, `word_ready` is high. Exactly N/16 secret words are taken. Secret coefficient 16k+m is bits [4m+3:4m] of word k, where bit 3 is the sign (1 = negative) and bits [2:0] are the magnitude.
- R3: Public coefficients form one little-endian bit stream in which coefficient i occupies stream bits [13i+12:13i]. The stream is taken as ceil(13N/64) words, and bits past the last coefficient are ignored.
- R4: At `done`, accumulator entry k equals the negacyclic product coefficient, which is the sum over i+j ≡ k (mod N) of a_i·s_j, negated when i+j ≥ N, reduced modulo 2^13.
- R5: A secret coefficient with the sign bit set subtracts the selected multiple. Magnitudes 5, 6 and 7 contribute zero, and so does a negative zero.
- R6: Each compute cycle rotates the secret buffer up by one entry. The entry leaving index N-1 enters index 0 with its sign inverted, so products that wrap past x^N are negated.
- R7: With a source that offers a word whenever `word_ready` is high, `done` is seen exactly N/16 + ceil(13N/64) + N cycles after the cycle that takes `start`. Of these, N are compute cycles. `done` lasts exactly one cycle.
- R8: Taking `start` in ST_IDLE clears the accumulator, so runs do not add together. A `start` while a run is active has no effect on the run or its result.
- R9: `rd_coef` shows accumulator entry `rd_idx` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (taken in ST_IDLE only) |
| word_valid | input | 1 | Input word present |
| word | input | 64 | Secret or public operand word |
| word_ready | output | 1 | Block takes `word` this cycle when valid |
| done | output | 1 | One-cycle end-of-run pulse |
| rd_idx | input | log2(N) | Result coefficient index |
| rd_coef | output | 13 | Result coefficient at `rd_idx` |

## Verification
Two things happen on the same clock edge: every lane's multiply-accumulate, and the negacyclic rotation that moves the top secret entry to index 0 with its sign flipped. This overlap is provoked in three ways. One run has a single non-zero secret at the top index. Other runs use uniform secrets of each value from -4 to +4. Extreme runs use all-(-4) and all-(+4) secrets against public coefficients of 8191. Every result coefficient is compared with a negacyclic schoolbook sum computed in the bench. A run-length count and a mid-run `start` check that the run takes the stated number of cycles and ignores a second start.

// File: rtl/pm_pkg.sv
package pm_pkg;
    localparam int unsigned SEC_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_RUN,
        ST_FIN
    } pm_state_e;

    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction
endpackage

// File: rtl/pm_multiples.sv
module pm_multiples #(
    parameter int unsigned CW = 13
) (
    input  logic [CW-1:0]      coef,
    output logic [4:0][CW-1:0] mult
);
    always_comb begin
        mult[0] = '0;
        mult[1] = coef;
        mult[2] = {coef[CW-2:0], 1'b0};
        mult[3] = coef + {coef[CW-2:0], 1'b0};
        mult[4] = {coef[CW-3:0], 2'b00};
    end
endmodule

// File: rtl/pm_unpack.sv
module pm_unpack #(
    parameter int unsigned CW = 13,
    parameter int unsigned WW = 64,
    localparam int unsigned BUFW = WW + CW - 1,
    localparam int unsigned FW = $clog2(BUFW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          take_word,
    input  logic [WW-1:0] word,
    input  logic          take_coef,
    output logic [CW-1:0] coef,
    output logic [FW-1:0] fill
);
    logic [BUFW-1:0] bits_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            bits_q <= '0;
            fill   <= '0;
        end else if (take_word) begin
            bits_q <= bits_q | (BUFW'(word) << fill);
            fill   <= fill + FW'(WW);
        end else if (take_coef) begin
            bits_q <= bits_q >> CW;
            fill   <= fill - FW'(CW);
        end
    end

    assign coef = bits_q[CW-1:0];

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        take_word |-> (fill < FW'(CW))); // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        take_coef |-> (fill >= FW'(CW))); // R3
    AST_COEF_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (take_coef && !clr) |=> (fill == $past(fill) - FW'(CW))); // R3
endmodule

// File: rtl/pm_lane.sv
module pm_lane #(
    parameter int unsigned CW = 13
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   load_en,
    input  logic [pm_pkg::SEC_W-1:0] load_val,
    input  logic                   step,
    input  logic [pm_pkg::SEC_W-1:0] shift_in,
    input  logic [4:0][CW-1:0]     mult,
    output logic [pm_pkg::SEC_W-1:0] sec_q,
    output logic [CW-1:0]          acc_q
);
    logic [CW-1:0] pick;
    logic [CW-1:0] acc_nxt;

    always_comb begin
        unique case (sec_q[2:0])
            3'd1:    pick = mult[1];
            3'd2:    pick = mult[2];
            3'd3:    pick = mult[3];
            3'd4:    pick = mult[4];
            default: pick = mult[0];
        endcase
        acc_nxt = sec_q[3] ? (acc_q - pick) : (acc_q + pick);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            sec_q <= '0;
        end else begin
            if (clr)       acc_q <= '0;
            else if (step) acc_q <= acc_nxt;
            if (load_en)   sec_q <= load_val;
            else if (step) sec_q <= shift_in;
        end
    end

    AST_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load_en) |=> (sec_q == $past(shift_in))); // R6
    AST_SEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load_en) |=> $stable(sec_q)); // R6
    AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_q == '0)); // R8
endmodule

// File: rtl/polymul_shared.sv
module polymul_shared #(
    parameter int unsigned N  = 256,
    parameter int unsigned CW = 13,
    parameter int unsigned WW = 64,
    localparam int unsigned IW = $clog2(N),
    localparam int unsigned PER_WORD = WW / pm_pkg::SEC_W,
    localparam int unsigned SWORDS = N / PER_WORD,
    localparam int unsigned PWORDS = pm_pkg::ceil_div(N * CW, WW),
    localparam int unsigned LW = $clog2(SWORDS + 1),
    localparam int unsigned PW = $clog2(PWORDS + 1),
    localparam int unsigned NW = $clog2(N + 1),
    localparam int unsigned FW = $clog2(WW + CW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          word_valid,
    input  logic [WW-1:0] word,
    output logic          word_ready,
    output logic          done,
    input  logic [IW-1:0] rd_idx,
    output logic [CW-1:0] rd_coef
);
    import pm_pkg::*;

    pm_state_e state_q, state_d;

    logic [LW-1:0] ld_cnt;
    logic [PW-1:0] pw_cnt;
    logic [NW-1:0] coef_cnt;
    logic [FW-1:0] fill;
    logic [CW-1:0] coef;
    logic [4:0][CW-1:0] mult;
    logic          take;
    logic          clr;
    logic          sec_take;
    logic          pub_take;
    logic          step;

    logic [SEC_W-1:0] sec_v [N];
    logic [CW-1:0]    acc_v [N];

    assign take     = word_valid && word_ready;
    assign clr      = (state_q == ST_IDLE) && start;
    assign sec_take = (state_q == ST_LOAD) && take;
    assign pub_take = (state_q == ST_RUN) && take;
    assign step     = (state_q == ST_RUN) && (fill >= FW'(CW));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_LOAD;
            ST_LOAD: if (sec_take && ld_cnt == LW'(SWORDS - 1)) state_d = ST_RUN;
            ST_RUN:  if (step && coef_cnt == NW'(N - 1)) state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        word_ready = 1'b0;
        done       = 1'b0;
        unique case (state_q)
            ST_LOAD: word_ready = 1'b1;
            ST_RUN:  word_ready = (fill < FW'(CW)) && (pw_cnt < PW'(PWORDS));
            ST_FIN:  done = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ld_cnt   <= '0;
            pw_cnt   <= '0;
            coef_cnt <= '0;
        end else begin
            if (sec_take) ld_cnt   <= ld_cnt + 1'b1;
            if (pub_take) pw_cnt   <= pw_cnt + 1'b1;
            if (step)     coef_cnt <= coef_cnt + 1'b1;
        end
    end

    pm_unpack #(.CW(CW), .WW(WW)) u_unpack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .take_word (pub_take),
        .word      (word),
        .take_coef (step),
        .coef      (coef),
        .fill      (fill)
    );

    pm_multiples #(.CW(CW)) u_mult (
        .coef (coef),
        .mult (mult)
    );

    for (genvar j = 0; j < N; j++) begin : g_lane
        logic [SEC_W-1:0] nb;
        logic             ld;
        if (j == 0) begin : g_wrap
            assign nb = {~sec_v[N-1][3], sec_v[N-1][2:0]};
        end else begin : g_link
            assign nb = sec_v[j-1];
        end
        assign ld = sec_take && (ld_cnt == LW'(j / PER_WORD));

        pm_lane #(.CW(CW)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (clr),
            .load_en  (ld),
            .load_val (word[SEC_W*(j % PER_WORD) +: SEC_W]),
            .step     (step),
            .shift_in (nb),
            .mult     (mult),
            .sec_q    (sec_v[j]),
            .acc_q    (acc_v[j])
        );
    end

    assign rd_coef = acc_v[rd_idx];

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_COEF_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        coef_cnt <= NW'(N)); // R7
    AST_FIN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIN) |-> (coef_cnt == NW'(N))); // R7
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RUN) && start) |=> (state_q == ST_RUN || state_q == ST_FIN)); // R8
    AST_LOAD_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (ld_cnt == LW'(SWORDS))); // R2
endmodule

// File: tb/test_polymul_shared.sv
module test_polymul_shared;
    localparam int N = 16;
    localparam int CW = 13;
    localparam int WW = 64;
    localparam int IW = $clog2(N);
    localparam int SW = N / 16;
    localparam int PWN = (N * CW + WW - 1) / WW;
    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          word_valid = 1'b0;
    logic [WW-1:0] word = '0;
    logic          word_ready;
    logic          done;
    logic [IW-1:0] rd_idx = '0;
    logic [CW-1:0] rd_coef;

    int checks = 0;
    int errors = 0;

    logic [CW-1:0] pub [N];
    logic [3:0]    code [N];

    always #(CLK_PERIOD / 2) clk = ~clk;

    polymul_shared #(.N(N), .CW(CW), .WW(WW)) i_polymul_shared (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .word_valid (word_valid),
        .word       (word),
        .word_ready (word_ready),
        .done       (done),
        .rd_idx     (rd_idx),
        .rd_coef    (rd_coef)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int sval(input logic [3:0] c);
        int m;
        m = (c[2:0] > 3'd4) ? 0 : int'(c[2:0]);
        return c[3] ? -m : m;
    endfunction

    task automatic run_job(input string tag, input bit mid_start);
        logic [WW-1:0]      q [SW + PWN];
        logic [PWN*WW-1:0]  stream;
        int                 exp_c [N];
        int                 qi;
        int                 cycles;
        bit                 seen;
        stream = '0;
        for (int i = 0; i < N; i++) stream[CW*i +: CW] = pub[i];
        for (int k = 0; k < SW; k++) begin
            q[k] = '0;
            for (int m = 0; m < 16; m++) q[k][4*m +: 4] = code[16*k + m];
        end
        for (int k = 0; k < PWN; k++) q[SW + k] = stream[WW*k +: WW];
        for (int k = 0; k < N; k++) exp_c[k] = 0;
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                if (i + j >= N) exp_c[(i + j) % N] -= int'(pub[i]) * sval(code[j]);
                else            exp_c[i + j]       += int'(pub[i]) * sval(code[j]);
            end
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        qi = 0;
        cycles = 0;
        seen = 1'b0;
        while (cycles < 2000) begin
            @(negedge clk);
            start = (mid_start && cycles == SW + 3);
            if (done) begin
                seen = 1'b1;
                word_valid = 1'b0;
                break;
            end
            if (cycles == 0) check({tag, " R2 ready in load"}, int'(word_ready), 1);
            if (word_ready && qi < SW + PWN) begin
                word_valid = 1'b1;
                word = q[qi];
                qi++;
            end else begin
                word_valid = 1'b0;
            end
            cycles++;
        end
        start = 1'b0;
        if (!seen) begin
            check({tag, " watchdog R7"}, 0, 1);
            return;
        end
        check({tag, " R7 latency"}, cycles, SW + PWN + N);
        @(negedge clk);
        check({tag, " R7 done one cycle"}, int'(done), 0);
        for (int k = 0; k < N; k++) begin
            rd_idx = IW'(k);
            #1;
            check({tag, " R4 R9 coef"}, int'(rd_coef), exp_c[k] & 32'h1FFF);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done after reset", int'(done), 0);
        check("R1 ready after reset", int'(word_ready), 0);
        for (int k = 0; k < N; k++) begin
            rd_idx = IW'(k);
            #1;
            check("R1 acc zero", int'(rd_coef), 0);
        end

        // uniform secret sweep -4..+4 (R5 sign, R3 packing)
        for (int v = -4; v <= 4; v++) begin
            for (int k = 0; k < N; k++) begin
                pub[k]  = CW'($urandom);
                code[k] = (v < 0) ? {1'b1, 3'(-v)} : {1'b0, 3'(v)};
            end
            run_job("R5 R3 uniform", 1'b0);
        end

        // extremes
        for (int k = 0; k < N; k++) begin pub[k] = 13'h1FFF; code[k] = 4'b1100; end
        run_job("R5 all -4 max", 1'b0);
        for (int k = 0; k < N; k++) begin pub[k] = 13'h1FFF; code[k] = 4'b0100; end
        run_job("R5 all +4 max", 1'b0);

        // wrap with sign inversion
        for (int k = 0; k < N; k++) begin pub[k] = CW'($urandom); code[k] = 4'b0000; end
        code[N-1] = 4'b0011;
        run_job("R6 top wrap", 1'b0);
        code[N-1] = 4'b1010;
        run_job("R6 top wrap neg", 1'b0);

        // out-of-range magnitudes and negative zero
        for (int k = 0; k < N; k++) begin
            pub[k] = CW'($urandom);
            case (k % 5)
                0: code[k] = 4'b0101;
                1: code[k] = 4'b1110;
                2: code[k] = 4'b0111;
                3: code[k] = 4'b1000;
                default: code[k] = 4'b0010;
            endcase
        end
        run_job("R5 odd codes", 1'b0);

        // random, with and without a start during the run (R8)
        for (int r = 0; r < 5; r++) begin
            for (int k = 0; k < N; k++) begin
                pub[k] = CW'($urandom);
                code[k] = {1'($urandom), 3'($urandom % 5)};
            end
            run_job((r % 2 == 1) ? "R8 mid start" : "R8 random rerun", r % 2 == 1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule